// File: doc/BRIEF.md
# DLL Output Phase Programming Sequencer

This block moves a delay-locked loop to a new sampling phase without glitching the clock the loop produces. A single-cycle start pulse carries a phase index from 0 to 15. The sequencer first gates the loop's clock output off, with the loop kept enabled and clock-data recovery switched to the external phase select. It then waits for the clock-output status to confirm that the clock has stopped. Next it writes the Gray-coded phase, turns the clock output back on, and waits for the status to confirm that the clock is running. Last, it hands control back to internal clock-data recovery.

Each of the two waits has its own poll limit, counted in microsecond ticks that a divider makes from the system clock. If the status does not arrive within the limit, the sequence is abandoned with an error pulse, and the control bits stay exactly where they were at that point. A busy flag covers the whole sequence. Start pulses that arrive while it is set are dropped.

Top module: `dll_phase_seq`

## Requirements
- R1: After reset all control outputs (`cdr_en_o`, `cdr_ext_o`, `dll_en_o`, `ckout_en_o`, `phase_sel_o`) and `busy_o`, `done_o`, `err_o` are 0.
- R2: An accepted start changes the controls in one register update, visible one cycle later: `cdr_en_o`=0, `ckout_en_o`=0, `cdr_ext_o`=1, `dll_en_o`=1, and `busy_o`=1.
- R3: While waiting for `ckout_status_i`=0, the sequencer counts ticks of TICK_DIV clocks from the start of the wait. If the status has not reached 0 after POLL_LIMIT ticks, `err_o` pulses for one cycle, exactly 1+POLL_LIMIT*TICK_DIV cycles after the start edge.
- R4: `phase_sel_o` receives the binary-reflected Gray code of the index (bit i = index[i] XOR index[i+1], top bit copied: 0,1,3,2,6,7,5,4,12,13,15,14,10,11,9,8). It changes only while `ckout_en_o` is 0, both before and after the change.
- R5: The cycle after the phase write, `ckout_en_o` is set. The sequencer then waits for `ckout_status_i`=1 under the same tick limit. With the status already at 0 when the sequence starts, a timeout here gives `err_o` 3+POLL_LIMIT*TICK_DIV cycles after the start edge.
- R6: On seeing status 1, the sequencer sets `cdr_en_o`=1 and `cdr_ext_o`=0 and pulses `done_o` for one cycle. `ckout_en_o` and `dll_en_o` stay 1 and `busy_o` drops. If status follows `ckout_en_o` after a lag of L+1 cycles, `done_o` comes 5+L cycles after the start edge when `ckout_en_o` was 0 beforehand, and 6+2L cycles after it when `ckout_en_o` was 1.
- R7: `busy_o` is 1 from the cycle after an accepted start until the cycle of `done_o` or `err_o`. A start while busy changes neither the phase written nor the timing of completion.
- R8: On a timeout, every control output keeps the value it had when the abort happened, and the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| phase_i | input | 4 | Phase index 0..15, sampled with start |
| ckout_status_i | input | 1 | Clock-output-enable status read back from the loop |
| cdr_en_o | output | 1 | Clock-data recovery enable |
| cdr_ext_o | output | 1 | External phase select for clock-data recovery |
| dll_en_o | output | 1 | Delay-locked loop enable |
| ckout_en_o | output | 1 | Clock output enable |
| phase_sel_o | output | 4 | Gray-coded output phase select |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | One-cycle pulse on a poll timeout |

## Verification
On every cycle the assertions check the gating rule for phase changes, the control values at the start of a sequence and at completion, the freeze of the controls on an abort, that the busy, done and error flags exclude each other, and that an error comes only from an expired poll counter. Some behaviour can only be shown by the bench scenarios with a delayed status model. These are the exact Gray value for every index, the completion and timeout latencies counted from the start edge, the timeout in each of the two waits, and that a start issued in mid-sequence leaves no trace.

// File: rtl/dll_phase_pkg.sv
package dll_phase_pkg;
  localparam int PH_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_OFF = 2'd1,
    ST_ARM      = 2'd2,
    ST_WAIT_ON  = 2'd3
  } seq_state_t;

  function automatic logic [PH_W-1:0] gray_of(input logic [PH_W-1:0] idx);
    return idx ^ (idx >> 1);
  endfunction
endpackage

// File: rtl/dll_us_tick.sv
module dll_us_tick #(
  parameter int TICK_DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV > 1) begin : g_div
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!run_i)          cnt_q <= '0;
        else if (cnt_q == LAST)   cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = run_i && (cnt_q == LAST);

      // R3: ticks are spaced, never back to back
      a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end else begin : g_pass
      assign tick_o = run_i;
    end
  endgenerate
endmodule

// File: rtl/dll_poll_limit.sv
module dll_poll_limit #(
  parameter int POLL_LIMIT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [PW-1:0] LAST = PW'(POLL_LIMIT - 1);

  logic [PW-1:0] polls_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        polls_q <= '0;
    else if (!run_i)   polls_q <= '0;
    else if (tick_i)   polls_q <= polls_q + 1'b1;
  end

  assign expired_o = run_i && tick_i && (polls_q == LAST);

  // R3: the count never passes the limit while a wait is running
  a_r3_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (polls_q <= LAST));
endmodule

// File: rtl/dll_phase_seq.sv
module dll_phase_seq
  import dll_phase_pkg::*;
#(
  parameter int TICK_DIV   = 200,
  parameter int POLL_LIMIT = 50
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic            ckout_status_i,
  output logic            cdr_en_o,
  output logic            cdr_ext_o,
  output logic            dll_en_o,
  output logic            ckout_en_o,
  output logic [PH_W-1:0] phase_sel_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o
);
  seq_state_t      state_q;
  logic [PH_W-1:0] phase_q;

  // named internal events
  logic waiting;
  logic status_match;
  logic us_tick;
  logic poll_expired;
  logic accept_start;

  assign waiting      = (state_q == ST_WAIT_OFF) || (state_q == ST_WAIT_ON);
  assign status_match = ((state_q == ST_WAIT_OFF) && !ckout_status_i) ||
                        ((state_q == ST_WAIT_ON)  &&  ckout_status_i);
  assign accept_start = (state_q == ST_IDLE) && start_i;

  dll_us_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (waiting),
    .tick_o (us_tick)
  );

  dll_poll_limit #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (waiting),
    .tick_i    (us_tick),
    .expired_o (poll_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      phase_q     <= '0;
      cdr_en_o    <= 1'b0;
      cdr_ext_o   <= 1'b0;
      dll_en_o    <= 1'b0;
      ckout_en_o  <= 1'b0;
      phase_sel_o <= '0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_start) begin
            phase_q    <= phase_i;
            cdr_en_o   <= 1'b0;
            ckout_en_o <= 1'b0;
            cdr_ext_o  <= 1'b1;
            dll_en_o   <= 1'b1;
            busy_o     <= 1'b1;
            state_q    <= ST_WAIT_OFF;
          end
        end
        ST_WAIT_OFF: begin
          if (status_match) begin
            phase_sel_o <= gray_of(phase_q);
            state_q     <= ST_ARM;
          end else if (poll_expired) begin
            err_o   <= 1'b1;
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_ARM: begin
          ckout_en_o <= 1'b1;
          state_q    <= ST_WAIT_ON;
        end
        ST_WAIT_ON: begin
          if (status_match) begin
            cdr_en_o  <= 1'b1;
            cdr_ext_o <= 1'b0;
            done_o    <= 1'b1;
            busy_o    <= 1'b0;
            state_q   <= ST_IDLE;
          end else if (poll_expired) begin
            err_o   <= 1'b1;
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: controls at the start of a sequence
  a_r2_gate_update: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (!cdr_en_o && !ckout_en_o && cdr_ext_o && dll_en_o));

  // R3, R5: an error only follows an expired poll window
  a_r3_err_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(poll_expired));

  // R4: phase field moves only with the clock output gated
  a_r4_phase_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_sel_o) |-> (!ckout_en_o && !$past(ckout_en_o)));

  // R6: completion leaves recovery on the internal path with clock running
  a_r6_done_fields: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cdr_en_o && !cdr_ext_o && ckout_en_o && dll_en_o));

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: busy starts only on a start request; flags exclusive
  a_r7_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  a_r7_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, done_o, err_o}));

  // R8: abort freezes every control output
  a_r8_abort_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $stable({cdr_en_o, cdr_ext_o, dll_en_o, ckout_en_o, phase_sel_o}));
endmodule

// File: tb/test_dll_phase_seq.sv
module test_dll_phase_seq;
  localparam int TDIV  = 4;
  localparam int LIMIT = 5;
  localparam int WIN   = TDIV * LIMIT;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] phase_i = '0;
  logic       ckout_status_i;
  logic       cdr_en_o, cdr_ext_o, dll_en_o, ckout_en_o;
  logic [3:0] phase_sel_o;
  logic       busy_o, done_o, err_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  dll_phase_seq #(.TICK_DIV(TDIV), .POLL_LIMIT(LIMIT)) i_dll_phase_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_i(phase_i),
    .ckout_status_i(ckout_status_i), .cdr_en_o(cdr_en_o), .cdr_ext_o(cdr_ext_o),
    .dll_en_o(dll_en_o), .ckout_en_o(ckout_en_o), .phase_sel_o(phase_sel_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  // status model: follows ckout_en_o after a programmable lag, or is forced
  int   lag = 0;
  bit   force_hi = 0, force_lo = 0;
  int   lag_cnt;
  logic st_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= 1'b0; lag_cnt <= 0;
    end else if (force_hi) begin
      st_q <= 1'b1; lag_cnt <= 0;
    end else if (force_lo) begin
      st_q <= 1'b0; lag_cnt <= 0;
    end else if (ckout_en_o != st_q) begin
      if (lag_cnt >= lag) begin st_q <= ckout_en_o; lag_cnt <= 0; end
      else lag_cnt <= lag_cnt + 1;
    end else lag_cnt <= 0;
  end
  assign ckout_status_i = st_q;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] gray_ref(input logic [3:0] b);
    logic [3:0] g;
    g[3] = b[3];
    for (int i = 0; i < 3; i++) g[i] = (b[i] != b[i+1]);
    return g;
  endfunction

  // R4 monitor: phase field may only change with clock output low
  logic [3:0] prev_ph;
  logic       prev_ck;
  bit         mon_on = 0;
  always @(negedge clk) begin
    if (mon_on && phase_sel_o != prev_ph)
      check(!prev_ck && !ckout_en_o, "R4 phase change while clock enabled",
            int'(ckout_en_o), 0);
    prev_ph = phase_sel_o;
    prev_ck = ckout_en_o;
  end

  // run one operation; returns edges from start to done/err
  task automatic do_op(input logic [3:0] ph, output int lat, output bit got_done);
    @(negedge clk);
    start_i = 1'b1; phase_i = ph;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    check(busy_o && !cdr_en_o && !ckout_en_o && cdr_ext_o && dll_en_o,
          "R2 gate update", {busy_o, cdr_en_o, ckout_en_o, cdr_ext_o, dll_en_o}, 5'b10011);
    while (!done_o && !err_o && lat < 200) begin
      check(busy_o, "R7 busy during sequence", int'(busy_o), 1);
      @(negedge clk);
      lat++;
    end
    got_done = done_o;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int  lat, exp_lat;
    bit  ok_done;
    logic [3:0] old_ph;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({cdr_en_o, cdr_ext_o, dll_en_o, ckout_en_o, phase_sel_o, busy_o, done_o, err_o} == '0,
          "R1 reset state", {cdr_en_o, cdr_ext_o, dll_en_o, ckout_en_o, phase_sel_o}, 0);
    rst_n = 1'b1;
    mon_on = 1;
    @(negedge clk);

    // R4 R6 sweep over every phase with varying status lag
    for (int p = 0; p < 16; p++) begin
      lag = p % 5;
      exp_lat = ckout_en_o ? (6 + 2 * lag) : (5 + lag);
      do_op(4'(p), lat, ok_done);
      check(ok_done, "R6 done seen", int'(ok_done), 1);
      check(lat == exp_lat, "R6 done latency", lat, exp_lat);
      check(phase_sel_o == gray_ref(4'(p)), "R4 gray phase", phase_sel_o, gray_ref(4'(p)));
      check(cdr_en_o && !cdr_ext_o && ckout_en_o && dll_en_o && !busy_o,
            "R6 final controls", {cdr_en_o, cdr_ext_o, ckout_en_o, dll_en_o, busy_o}, 5'b10110);
      @(negedge clk);
      check(!done_o, "R6 done single pulse", int'(done_o), 0);
    end

    // R7 start while busy is ignored
    lag = 3;
    @(negedge clk);
    start_i = 1'b1; phase_i = 4'd3;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 200) begin
      if (lat == 3 || lat == 8) begin start_i = 1'b1; phase_i = 4'd9; end
      else start_i = 1'b0;
      @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
    check(lat == 12, "R7 latency unchanged by extra start", lat, 12);
    check(phase_sel_o == gray_ref(4'd3), "R7 extra start ignored", phase_sel_o, gray_ref(4'd3));
    @(negedge clk);
    check(!busy_o, "R7 idle after extra start", int'(busy_o), 0);

    // R3 R8 timeout waiting for status low
    old_ph = phase_sel_o;
    force_hi = 1;
    do_op(4'd12, lat, ok_done);
    check(err_o && !ok_done, "R3 timeout on gate-off wait", int'(err_o), 1);
    check(lat == 1 + WIN, "R3 timeout latency", lat, 1 + WIN);
    check(!cdr_en_o && cdr_ext_o && dll_en_o && !ckout_en_o && !busy_o,
          "R8 frozen controls off-wait", {cdr_en_o, cdr_ext_o, dll_en_o, ckout_en_o, busy_o}, 5'b01100);
    check(phase_sel_o == old_ph, "R8 phase kept on abort", phase_sel_o, old_ph);
    @(negedge clk);
    check(!err_o, "R3 error single pulse", int'(err_o), 0);
    force_hi = 0;
    repeat (4) @(negedge clk);

    // R5 R8 timeout waiting for status high
    force_lo = 1;
    do_op(4'd6, lat, ok_done);
    check(err_o && !ok_done, "R5 timeout on enable wait", int'(err_o), 1);
    check(lat == 3 + WIN, "R5 timeout latency", lat, 3 + WIN);
    check(!cdr_en_o && cdr_ext_o && dll_en_o && ckout_en_o && !busy_o,
          "R8 frozen controls on-wait", {cdr_en_o, cdr_ext_o, dll_en_o, ckout_en_o, busy_o}, 5'b01110);
    check(phase_sel_o == gray_ref(4'd6), "R5 phase written before abort", phase_sel_o, gray_ref(4'd6));
    force_lo = 0;
    repeat (4) @(negedge clk);

    // recovery after abort
    lag = 0;
    do_op(4'd15, lat, ok_done);
    check(ok_done && phase_sel_o == gray_ref(4'd15), "R8 recovery after abort",
          phase_sel_o, gray_ref(4'd15));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule